// File: doc/BRIEF.md
# Embedded-Clock Frame Boundary Finder

This block takes a recovered serial bit stream, one bit per clock, and works out where the symbol boundaries are. Each symbol is twelve bits long. It starts with a high start bit, carries ten data bits with the least significant first, and closes with a low end bit. The only edge the line is sure to show in every symbol is the rise from an end bit into the next start bit. Any data pattern can be on the line while the search runs, so the block does not wait for a special word.

A free-running phase counter gives every bit a slot number from 0 to 11. Slot 0 is the first bit taken after reset. The block keeps one candidate flag per slot. Once per frame, it clears the flag of any slot that shows no rising edge. When a single flag is left, the block reports alignment and the slot of the start bit. From then on it puts out one ten-bit word per symbol, and it checks the boundary edge in every frame. A missing edge gives a one-cycle miss pulse, drops alignment and starts the search again.

Top module: `fb_frame_finder`

## Requirements
- R1: While reset is high and just after it, `aligned`, `word_vld` and `edge_miss` are low.
- R2: The phase counter is 0 for the first bit sampled after reset and wraps from 11 to 0. A rising edge at slot k means the bit in slot k is 1 and the bit sampled one clock earlier is 0, including across the wrap. The first bit after reset has no earlier bit and is never tested.
- R3: `aligned` rises once exactly one candidate slot is left. `bound_pos` then gives the slot of the start bit, and it does not change while `aligned` stays high.
- R4: If the data puts a rising edge at the same extra slot in every frame, at least two candidates survive and `aligned` never rises.
- R5: A stream of sync symbols, whose data word is 0x01F (six ones, then six zeros, counting the start and end bits), produces alignment by the end of the second symbol after reset, whatever the offset.
- R6: While aligned, `word_vld` pulses for one clock in the cycle after the last data bit is sampled. `word_out` bit i holds the i-th data bit after the start bit. A word is given only if all of its data bits arrived while aligned.
- R7: While aligned, if the slot in `bound_pos` shows no rising edge, `edge_miss` pulses for one clock and `aligned` falls in the same cycle. All twelve candidates are then restored, and a later clean stream aligns again.
- R8: If every candidate has been eliminated, all twelve are restored on the next clock, so a stream with no edges does not stop a later alignment.
- R9: The last candidate can be about to be declared in the same cycle that its own slot is tested. If that slot shows no rising edge, no alignment is declared and the candidate is eliminated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Recovered serial bit, one per clock |
| aligned | output | 1 | High once the boundary slot is settled |
| bound_pos | output | 4 | Slot of the start bit while aligned |
| word_out | output | 10 | Last assembled data word, bit 0 first received |
| word_vld | output | 1 | One-clock strobe for a new `word_out` |
| edge_miss | output | 1 | One-clock pulse when the boundary edge is absent |

## Verification
The lock decision and the test of the surviving slot's own edge can fall in the same cycle. This happens when the last wrong candidate is eliminated in slot 11 and the survivor is slot 0. The bench provokes it by sending one clean sync symbol that starts at slot 0 right after reset. It then sends the next symbol either with its start bit intact or with its start bit forced low. It checks `aligned` at that very cycle. With the edge present, alignment must appear there. With the edge absent, `aligned` and `edge_miss` must both stay low, and the block must align again, at slot 0, on the sync symbols that follow.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int unsigned FB_DATA_W     = 10;
  localparam int unsigned FB_FRAME_BITS = 2;

  function automatic int unsigned fb_sym_bits(input int unsigned dw);
    return dw + FB_FRAME_BITS;
  endfunction
endpackage

// File: rtl/fb_bit_front.sv
module fb_bit_front #(
  parameter int unsigned SYM_W = 12,
  parameter int unsigned POS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_bit,
  output logic [POS_W-1:0] phase,
  output logic             rise,
  output logic             primed
);
  logic [POS_W-1:0] phase_q;
  logic             prev_q;
  logic             primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      phase_q  <= (phase_q == POS_W'(SYM_W - 1)) ? '0 : phase_q + POS_W'(1);
      prev_q   <= ser_bit;
      primed_q <= 1'b1;
    end
  end

  assign phase  = phase_q;
  assign rise   = ser_bit & ~prev_q;
  assign primed = primed_q;
endmodule

// File: rtl/fb_cand_mask.sv
module fb_cand_mask #(
  parameter int unsigned SYM_W = 12,
  parameter int unsigned POS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] phase,
  input  logic             rise,
  input  logic             primed,
  output logic             aligned,
  output logic [POS_W-1:0] bpos,
  output logic             miss
);
  logic [SYM_W-1:0] mask_q;
  logic             aligned_q;
  logic [POS_W-1:0] bpos_q;
  logic             miss_q;
  logic [POS_W-1:0] surv;
  logic             one_left;
  logic             surv_fails;

  always_comb begin
    surv = '0;
    for (int i = 0; i < SYM_W; i++) begin
      if (mask_q[i]) surv = POS_W'(i);
    end
  end

  assign one_left   = $onehot(mask_q);
  assign surv_fails = (phase == surv) && !rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '1;
      aligned_q <= 1'b0;
      bpos_q    <= '0;
      miss_q    <= 1'b0;
    end else begin
      miss_q <= 1'b0;
      if (aligned_q) begin
        if (phase == bpos_q && !rise) begin
          miss_q    <= 1'b1;
          aligned_q <= 1'b0;
          mask_q    <= '1;
        end
      end else if (mask_q == '0) begin
        mask_q <= '1;
      end else if (one_left && !surv_fails) begin
        aligned_q <= 1'b1;
        bpos_q    <= surv;
      end else if (primed && !rise) begin
        mask_q[phase] <= 1'b0;
      end
    end
  end

  assign aligned = aligned_q;
  assign bpos    = bpos_q;
  assign miss    = miss_q;
endmodule

// File: rtl/fb_word_asm.sv
module fb_word_asm #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned SYM_W  = 12,
  parameter int unsigned POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  input  logic [POS_W-1:0]  phase,
  input  logic [POS_W-1:0]  bpos,
  input  logic              aligned,
  output logic [DATA_W-1:0] word,
  output logic              word_vld
);
  logic [POS_W-1:0]  rel;
  logic [POS_W-1:0]  slot;
  logic [DATA_W-2:0] sh_q;
  logic [DATA_W-1:0] word_q;
  logic              vld_q;
  logic              coll_q;

  always_comb begin
    if (phase >= bpos) rel = phase - bpos;
    else               rel = phase + POS_W'(SYM_W) - bpos;
    slot = rel - POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (!aligned) begin
        coll_q <= 1'b0;
      end else begin
        if (rel >= POS_W'(1) && rel <= POS_W'(DATA_W - 1)) sh_q[slot] <= ser_bit;
        if (rel == POS_W'(1)) coll_q <= 1'b1;
        if (rel == POS_W'(DATA_W)) begin
          if (coll_q) begin
            word_q <= {ser_bit, sh_q};
            vld_q  <= 1'b1;
          end
          coll_q <= 1'b0;
        end
      end
    end
  end

  assign word     = word_q;
  assign word_vld = vld_q;
endmodule

// File: rtl/fb_frame_finder.sv
module fb_frame_finder import fb_pkg::*; #(
  parameter  int unsigned DATA_W = FB_DATA_W,
  localparam int unsigned SYM_W  = fb_sym_bits(DATA_W),
  localparam int unsigned POS_W  = $clog2(SYM_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  output logic              aligned,
  output logic [POS_W-1:0]  bound_pos,
  output logic [DATA_W-1:0] word_out,
  output logic              word_vld,
  output logic              edge_miss
);
  logic [POS_W-1:0] phase;
  logic             rise;
  logic             primed;

  fb_bit_front #(.SYM_W(SYM_W), .POS_W(POS_W)) u_front (
    .clk(clk), .rst(rst), .ser_bit(ser_bit),
    .phase(phase), .rise(rise), .primed(primed)
  );

  fb_cand_mask #(.SYM_W(SYM_W), .POS_W(POS_W)) u_mask (
    .clk(clk), .rst(rst), .phase(phase), .rise(rise), .primed(primed),
    .aligned(aligned), .bpos(bound_pos), .miss(edge_miss)
  );

  fb_word_asm #(.DATA_W(DATA_W), .SYM_W(SYM_W), .POS_W(POS_W)) u_asm (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .phase(phase),
    .bpos(bound_pos), .aligned(aligned),
    .word(word_out), .word_vld(word_vld)
  );
endmodule

// File: rtl/fb_frame_finder_chk.sv
module fb_frame_finder_chk #(
  parameter int unsigned SYM_W = 12,
  parameter int unsigned POS_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             aligned,
  input logic [POS_W-1:0] bound_pos,
  input logic             word_vld,
  input logic             edge_miss
);
  AST_MISS_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst) edge_miss |-> ($past(aligned) && !aligned)); // R7
  AST_MISS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) edge_miss |=> !edge_miss); // R7
  AST_WORD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst) word_vld |-> $past(aligned)); // R6
  AST_WORD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) word_vld |=> !word_vld); // R6
  AST_POS_HELD: assert property (@(posedge clk) disable iff (rst) (aligned && $past(aligned)) |-> $stable(bound_pos)); // R3
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst) aligned |-> (bound_pos < POS_W'(SYM_W))); // R3
endmodule

bind fb_frame_finder fb_frame_finder_chk #(.SYM_W(SYM_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .aligned(aligned), .bound_pos(bound_pos),
  .word_vld(word_vld), .edge_miss(edge_miss)
);

// File: tb/test_fb_frame_finder.sv
`timescale 1ns/1ps
module test_fb_frame_finder;
  localparam int DW = 10;
  localparam int PW = 4;

  // {start offset, mode (0 sync / 1 random), expected slot, frame budget}
  localparam logic [19:0] VEC [6] = '{
    {4'd0, 4'd0, 4'd0,  8'd2},
    {4'd1, 4'd0, 4'd11, 8'd2},
    {4'd5, 4'd0, 4'd7,  8'd2},
    {4'd0, 4'd1, 4'd0,  8'd60},
    {4'd7, 4'd1, 4'd5,  8'd60},
    {4'd3, 4'd1, 4'd9,  8'd60}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ser_bit = 1'b0;
  logic          aligned;
  logic [PW-1:0] bound_pos;
  logic [DW-1:0] word_out;
  logic          word_vld;
  logic          edge_miss;

  int n_chk = 0;
  int n_bad = 0;
  int miss_cnt = 0;
  int word_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  fb_frame_finder i_fb_frame_finder (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .aligned(aligned),
    .bound_pos(bound_pos), .word_out(word_out), .word_vld(word_vld),
    .edge_miss(edge_miss)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit is_last_data, input logic [DW-1:0] w);
    ser_bit = b;
    @(posedge clk);
    @(negedge clk);
    if (word_vld) begin
      word_cnt++;
      check("R6 strobe right after data bit 9", int'(is_last_data), 1);
      check("R6 word content", int'(word_out), int'(w));
    end
    if (edge_miss) begin
      miss_cnt++;
      check("R7 aligned low with miss pulse", int'(aligned), 0);
    end
  endtask

  task automatic send_sym(input logic [DW-1:0] w, input int skip, input bit bad_start);
    for (int b = skip; b < DW + 2; b++) begin
      logic sb;
      if (b == 0)           sb = !bad_start;
      else if (b == DW + 1) sb = 1'b0;
      else                  sb = w[b-1];
      send_bit(sb, (b == DW), w);
    end
  endtask

  task automatic gen_word(input int mode, output logic [DW-1:0] w);
    if (mode == 0) begin
      w = 10'h01F;
    end else begin
      for (int s = 0; s < 10; s++)
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w = lfsr[DW-1:0];
      if (mode == 2) begin
        w[4] = 1'b0;
        w[5] = 1'b1;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ser_bit = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 aligned low in reset", int'(aligned), 0);
    check("R1 word_vld low in reset", int'(word_vld), 0);
    check("R1 edge_miss low in reset", int'(edge_miss), 0);
    rst = 1'b0;
    miss_cnt = 0;
    word_cnt = 0;
  endtask

  task automatic run_until_lock(input int mode, input int budget);
    logic [DW-1:0] w;
    for (int f = 0; f < budget && !aligned; f++) begin
      gen_word(mode, w);
      send_sym(w, 0, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] w;
    int frames;
    bit amb;

    // Table walk: sync and live data at several offsets (R2 R3 R5 R6)
    for (int v = 0; v < 6; v++) begin
      int off, mode, pos, budget;
      off    = int'(VEC[v][19:16]);
      mode   = int'(VEC[v][15:12]);
      pos    = int'(VEC[v][11:8]);
      budget = int'(VEC[v][7:0]);
      do_reset();
      gen_word(mode, w);
      send_sym(w, off, 1'b0);
      frames = 1;
      while (!aligned && frames < budget) begin
        gen_word(mode, w);
        send_sym(w, 0, 1'b0);
        frames++;
      end
      if (mode == 0) check("R5 sync aligned within two symbols", int'(aligned), 1);
      else           check("R3 live data aligned", int'(aligned), 1);
      check("R2 R3 boundary slot", int'(bound_pos), pos);
      word_cnt = 0;
      repeat (6) begin
        gen_word(mode, w);
        send_sym(w, 0, 1'b0);
      end
      check("R6 one word per symbol", word_cnt, 6);
      check("R7 no miss on clean stream", miss_cnt, 0);
    end

    // R4: permanent extra edge keeps two candidates
    do_reset();
    amb = 1'b0;
    repeat (40) begin
      gen_word(2, w);
      send_sym(w, 0, 1'b0);
      if (aligned) amb = 1'b1;
    end
    check("R4 no alignment with repeating extra edge", int'(amb), 0);

    // R8: edge-free stream empties the mask, then live data aligns at slot 4
    do_reset();
    repeat (40) send_bit(1'b0, 1'b0, '0);
    check("R8 no alignment on flat line", int'(aligned), 0);
    run_until_lock(1, 60);
    check("R8 aligned after mask reload", int'(aligned), 1);
    check("R8 slot after reload", int'(bound_pos), 4);

    // R7: corrupted start bit while aligned
    repeat (2) begin
      gen_word(1, w);
      send_sym(w, 0, 1'b0);
    end
    miss_cnt = 0;
    gen_word(1, w);
    send_sym(w, 0, 1'b1);
    check("R7 one miss pulse", miss_cnt, 1);
    run_until_lock(1, 60);
    check("R7 realigned after miss", int'(aligned), 1);
    check("R7 slot after realign", int'(bound_pos), 4);
    check("R7 no further miss", miss_cnt, 1);

    // R9: lock decision coincides with survivor test, edge absent
    do_reset();
    send_sym(10'h01F, 0, 1'b0);
    send_bit(1'b0, 1'b0, 10'h01F);
    check("R9 no lock when survivor edge absent", int'(aligned), 0);
    check("R9 no miss before lock", int'(edge_miss), 0);
    send_sym(10'h01F, 1, 1'b0);
    run_until_lock(0, 4);
    check("R9 aligned on following sync", int'(aligned), 1);
    check("R9 slot on following sync", int'(bound_pos), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule